// File: doc/BRIEF.md
# Add-Only Byte Memory with Page Locks

This block holds a 128-byte one-time-programmable store, split into four 32-byte pages, behind a single-cycle request/acknowledge port. A request carries an operation code, a byte address and a data byte. Reads return the addressed byte. Program requests can only clear bits: the stored byte becomes the bitwise AND of its old value and the supplied byte, so data already written is never disturbed.

Page 0 holds a factory record that is loaded at reset and is permanently write-protected. The record is laid out as follows:

- a record length byte;
- a 32-bit project tag;
- a 64-bit node identifier;
- an inverted CRC-16 over the preceding bytes.

Pages 1 to 3 start blank, with every byte at FFh. Each of these pages can be locked by a lock request, which sets a one-time status bit for the page. A locked page rejects all later program requests. Rejected programs raise an error flag in the acknowledge cycle.

Reset stands for restoring the part's initial image. It reloads the factory record, blanks pages 1 to 3, and clears the status bits of pages 1 to 3.

Top module: `aom_write_ctrl`

## Requirements
- R1: After reset, page 0 holds the factory record, with multi-byte fields stored least significant byte first:
  - address 00h holds 0Ch;
  - addresses 01h–04h hold the project tag 00001128h;
  - addresses 05h–0Ch hold the node identifier (default 006035234567ABCDh);
  - addresses 0Dh–0Eh hold the inverted CRC-16 (polynomial x^16+x^15+x^2+1, reflected, zero start) over bytes 00h–0Ch, which is FFh, 3Eh for the default identifier;
  - addresses 0Fh–1Fh hold FFh.
- R2: After reset, every byte of addresses 20h–7Fh reads FFh, and the lock status reads 0001b (only page 0 locked).
- R3: Operation codes on req_op are 00 read, 01 program, 10 lock page, 11 read lock status. Every cycle with req_valid high produces ack high exactly one cycle later, and ack is never high otherwise.
- R4: A program request to an unlocked page stores the old byte AND req_data.
- R5: A program request to page 0 (address bits [6:5] = 00) is answered with err high and leaves the byte unchanged.
- R6: A lock request sets the status bit of the page in req_addr[6:5]. Every later program request to that page, including one in the very next cycle, is answered with err and leaves memory unchanged.
- R7: A lock status read returns bit i = lock state of page i in rd_data[3:0] with rd_data[7:4] zero. A set status bit stays set until reset.
- R8: A read returns the addressed byte on rd_data in the ack cycle, whether or not its page is locked.
- R9: err is high only in the ack cycle of a rejected program request. Reads, status reads and lock requests, including a lock of page 0 or of an already-locked page, never raise err.
- R10: Between resets no stored bit ever changes from 0 to 1, and a program that would set a bit leaves that bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the initial image |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (read, program, lock page, read lock status) |
| req_addr | input | 7 | Byte address; bits [6:5] select the page |
| req_data | input | 8 | Program data byte |
| ack | output | 1 | Response for the request of the previous cycle |
| err | output | 1 | Program rejected (valid with ack) |
| rd_data | output | 8 | Read byte or lock status (valid with ack) |

## Verification
The bench attacks the following corner cases:

- **Repeated programs to one byte.** Programs with overlapping and with complementary bit patterns are sent to the same byte. A design that overwrites instead of ANDing reads back the last pattern. A design that ORs brings cleared bits back to 1.
- **Protected writes.** Writes aimed at the factory page and at freshly locked pages must leave the contents intact and raise err. A design with a missing or late lock check would corrupt the record or accept a program issued one cycle after the lock.
- **Lock requests without error.** Lock requests on page 0 and on already-locked pages must not raise err. A design that flags them would report false rejections.
- **Reset mid-run.** A reset in the middle of the run must clear the user locks and blank the user pages. A design that reloads them wrongly shows stale data or a stale status.

// File: rtl/aom_pkg.sv
package aom_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned TAG_BYTES = 4;
    localparam int unsigned ID_BYTES  = 8;
    localparam int unsigned REC_BYTES = 1 + TAG_BYTES + ID_BYTES;
    localparam logic [BYTE_W-1:0] BLANK_BYTE = 8'hFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_PROG = 2'b01,
        OP_LOCK = 2'b10,
        OP_STAT = 2'b11
    } aom_op_e;

    typedef struct packed {
        logic              ack;
        logic              err;
        logic [BYTE_W-1:0] data;
    } aom_rsp_t;

    // One byte of CRC-16, LSB-first with reflected polynomial.
    function automatic logic [15:0] crc16_step(logic [15:0] crc_in, logic [BYTE_W-1:0] b);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int unsigned k = 0; k < BYTE_W; k++) begin
            fb = c[0] ^ b[k];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction

    // Bytes of the factory record before the check field.
    function automatic logic [BYTE_W-1:0] record_byte(int unsigned idx,
                                                      logic [63:0] node,
                                                      logic [31:0] tag);
        logic [BYTE_W-1:0] b;
        b = BLANK_BYTE;
        if (idx == 0)
            b = 8'(TAG_BYTES + ID_BYTES);
        else if (idx <= TAG_BYTES)
            b = tag[8*(idx-1) +: 8];
        else if (idx < REC_BYTES)
            b = node[8*(idx-1-TAG_BYTES) +: 8];
        return b;
    endfunction

    // Full factory page content at byte index idx.
    function automatic logic [BYTE_W-1:0] factory_byte(int unsigned idx,
                                                       logic [63:0] node,
                                                       logic [31:0] tag);
        logic [15:0] crc;
        crc = 16'h0000;
        for (int unsigned k = 0; k < REC_BYTES; k++)
            crc = crc16_step(crc, record_byte(k, node, tag));
        crc = ~crc;
        if (idx < REC_BYTES)
            return record_byte(idx, node, tag);
        else if (idx == REC_BYTES)
            return crc[7:0];
        else if (idx == REC_BYTES + 1)
            return crc[15:8];
        return BLANK_BYTE;
    endfunction

endpackage

// File: rtl/aom_cell_array.sv
module aom_cell_array
    import aom_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned NUM_PAGES  = 4,
    parameter logic [63:0] NODE_ID    = 64'h006035234567ABCD,
    parameter logic [31:0] PROJECT_ID = 32'h00001128,
    localparam int unsigned DEPTH     = PAGE_BYTES * NUM_PAGES,
    localparam int unsigned ADDR_W    = $clog2(DEPTH),
    localparam int unsigned PAGE_W    = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_byte
);

    logic [BYTE_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [BYTE_W-1:0] INIT_VAL =
            (i < PAGE_BYTES) ? factory_byte(i, NODE_ID, PROJECT_ID) : BLANK_BYTE;

        always_ff @(posedge clk) begin
            if (rst)
                cells[i] <= INIT_VAL;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                cells[i] <= cells[i] & wr_data;
        end

        // no bit may rise between resets
        assert_no_bit_set_R10: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ((cells[i] & ~$past(cells[i])) == '0));
    end

    assign rd_byte = cells[rd_addr];

    // the factory page never receives a write strobe
    assert_no_factory_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr[ADDR_W-1 -: PAGE_W] != '0));

endmodule

// File: rtl/aom_lock_bits.sv
module aom_lock_bits #(
    parameter int unsigned NUM_PAGES = 4,
    localparam int unsigned PAGE_W  = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_en,
    input  logic [PAGE_W-1:0]    set_page,
    output logic [NUM_PAGES-1:0] locked
);

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        if (p == 0) begin : g_fixed
            assign locked[p] = 1'b1;
        end else begin : g_user
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (set_en && (set_page == PAGE_W'(p)))
                    bit_q <= 1'b1;
            end
            assign locked[p] = bit_q;

            assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
                locked[p] |=> locked[p]);
        end
    end

endmodule

// File: rtl/aom_write_ctrl.sv
module aom_write_ctrl
    import aom_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned NUM_PAGES  = 4,
    parameter logic [63:0] NODE_ID    = 64'h006035234567ABCD,
    parameter logic [31:0] PROJECT_ID = 32'h00001128
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    req_valid,
    input  logic [1:0]                              req_op,
    input  logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] req_addr,
    input  logic [7:0]                              req_data,
    output logic                                    ack,
    output logic                                    err,
    output logic [7:0]                              rd_data
);

    localparam int unsigned DEPTH  = PAGE_BYTES * NUM_PAGES;
    localparam int unsigned ADDR_W = $clog2(DEPTH);
    localparam int unsigned PAGE_W = $clog2(NUM_PAGES);

    aom_op_e             op;
    logic [PAGE_W-1:0]   page;
    logic [NUM_PAGES-1:0] locked;
    logic                prog_req;
    logic                prog_ok;
    logic                prog_bad;
    logic                lock_req;
    logic [BYTE_W-1:0]   cell_byte;
    logic [BYTE_W-1:0]   stat_byte;
    aom_rsp_t            rsp_d;
    aom_rsp_t            rsp_q;

    assign op       = aom_op_e'(req_op);
    assign page     = req_addr[ADDR_W-1 -: PAGE_W];
    assign prog_req = req_valid && (op == OP_PROG);
    assign prog_ok  = prog_req && !locked[page];
    assign prog_bad = prog_req &&  locked[page];
    assign lock_req = req_valid && (op == OP_LOCK);

    aom_lock_bits #(
        .NUM_PAGES (NUM_PAGES)
    ) u_locks (
        .clk      (clk),
        .rst      (rst),
        .set_en   (lock_req),
        .set_page (page),
        .locked   (locked)
    );

    aom_cell_array #(
        .PAGE_BYTES (PAGE_BYTES),
        .NUM_PAGES  (NUM_PAGES),
        .NODE_ID    (NODE_ID),
        .PROJECT_ID (PROJECT_ID)
    ) u_cells (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (prog_ok),
        .wr_addr (req_addr),
        .wr_data (req_data),
        .rd_addr (req_addr),
        .rd_byte (cell_byte)
    );

    always_comb begin
        stat_byte = '0;
        stat_byte[NUM_PAGES-1:0] = locked;
    end

    always_comb begin
        rsp_d.ack  = req_valid;
        rsp_d.err  = prog_bad;
        rsp_d.data = '0;
        if (req_valid) begin
            unique case (op)
                OP_READ: rsp_d.data = cell_byte;
                OP_STAT: rsp_d.data = stat_byte;
                default: rsp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign ack     = rsp_q.ack;
    assign err     = rsp_q.err;
    assign rd_data = rsp_q.data;

    assert_ack_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ack);

    assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(req_valid));

    assert_err_only_prog_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> (ack && ($past(req_op) == OP_PROG)));

    assert_locked_prog_rejected_R6: assert property (@(posedge clk) disable iff (rst)
        (prog_req && locked[page]) |=> err);

endmodule

// File: tb/aom_write_ctrl_test.sv
`timescale 1ns/1ps
module aom_write_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [6:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       ack;
    logic       err;
    logic [7:0] rd_data;

    always #2 clk = ~clk;

    aom_write_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .ack       (ack),
        .err       (err),
        .rd_data   (rd_data)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic sent_prev = 1'b0;

    logic [7:0] model [128];
    logic [3:0] model_lock;
    logic [8:0] exp_q [$];
    string      tag_q [$];

    function automatic logic [7:0] image_byte(int idx);
        case (idx)
            0: return 8'h0C;  1: return 8'h28;  2: return 8'h11;
            3: return 8'h00;  4: return 8'h00;  5: return 8'hCD;
            6: return 8'hAB;  7: return 8'h67;  8: return 8'h45;
            9: return 8'h23; 10: return 8'h35; 11: return 8'h60;
           12: return 8'h00; 13: return 8'hFF; 14: return 8'h3E;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++)
            model[i] = (i < 32) ? image_byte(i) : 8'hFF;
        model_lock = 4'b0001;
    endtask

    // driver: compute expectation from the requirements, push, drive
    task automatic issue(input logic [1:0] op, input logic [6:0] a,
                         input logic [7:0] d, input string tag);
        logic [7:0] er;
        logic       ee;
        logic [1:0] pg;
        pg = a[6:5];
        er = 8'h00;
        ee = 1'b0;
        case (op)
            2'b00: er = model[a];
            2'b01: if (model_lock[pg]) ee = 1'b1;
                   else model[a] = model[a] & d;
            2'b10: model_lock[pg] = 1'b1;
            default: er = {4'b0000, model_lock};
        endcase
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_data  = d;
        exp_q.push_back({ee, er});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: compare responses against the scoreboard
    always @(negedge clk) begin
        logic [8:0] e;
        string      t;
        #1;
        if (sent_prev || ack) begin
            checks++;
            if (ack !== sent_prev) begin
                failures++;
                $display("FAIL R3 ack timing: actual=%b expected=%b", ack, sent_prev);
            end
        end
        if (ack === 1'b1 && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (err !== e[8] || rd_data !== e[7:0]) begin
                failures++;
                $display("FAIL %s: actual err=%b rd=%h expected err=%b rd=%h",
                         t, err, rd_data, e[8], e[7:0]);
            end
        end
        sent_prev = req_valid && !rst;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        checks++;
        if (ack !== 1'b0 || err !== 1'b0) begin
            failures++;
            $display("FAIL R3 reset state: actual ack=%b err=%b expected ack=0 err=0", ack, err);
        end

        // R1, R2, R8: full image after reset
        for (int i = 0; i < 128; i++)
            issue(2'b00, 7'(i), 8'h00, (i < 32) ? "R1 factory byte" : "R2 blank byte");
        issue(2'b11, 7'h00, 8'h00, "R2 R7 status after reset");

        // R4, R10: AND rule on a user byte
        issue(2'b01, 7'h20, 8'h0F, "R4 program 0F");
        issue(2'b00, 7'h20, 8'h00, "R4 read after first program");
        issue(2'b01, 7'h20, 8'hF3, "R4 program F3");
        issue(2'b00, 7'h20, 8'h00, "R4 read AND result");
        issue(2'b01, 7'h20, 8'hFF, "R10 program FF cannot set bits");
        issue(2'b00, 7'h20, 8'h00, "R10 read unchanged");
        issue(2'b01, 7'h3F, 8'hA5, "R4 program page1 top byte");
        issue(2'b01, 7'h3F, 8'h5A, "R10 complementary pattern");
        issue(2'b00, 7'h3F, 8'h00, "R10 read cleared byte");

        // R5: factory page rejects programs
        issue(2'b01, 7'h05, 8'h00, "R5 program factory byte");
        issue(2'b00, 7'h05, 8'h00, "R5 factory byte intact");
        issue(2'b01, 7'h1F, 8'h00, "R5 program factory tail");
        issue(2'b00, 7'h1F, 8'h00, "R5 factory tail intact");

        // R6: lock page 2, program in the very next cycle
        issue(2'b10, 7'h40, 8'h00, "R9 lock page 2 no err");
        issue(2'b01, 7'h40, 8'h00, "R6 program right after lock");
        issue(2'b01, 7'h5E, 8'h12, "R6 program locked page");
        issue(2'b00, 7'h40, 8'h00, "R8 read locked page");
        issue(2'b00, 7'h5E, 8'h00, "R8 read locked page byte");
        issue(2'b11, 7'h00, 8'h00, "R7 status page 2 locked");

        // R9: locking page 0 or a locked page gives no error
        issue(2'b10, 7'h00, 8'h00, "R9 lock page 0");
        issue(2'b10, 7'h41, 8'h00, "R9 relock page 2");
        issue(2'b11, 7'h00, 8'h00, "R7 status unchanged");

        // page 3 still writable, then lock it
        issue(2'b01, 7'h7F, 8'h5A, "R4 program page 3");
        issue(2'b00, 7'h7F, 8'h00, "R4 read page 3");
        issue(2'b10, 7'h60, 8'h00, "R9 lock page 3");
        issue(2'b01, 7'h7F, 8'h00, "R6 page 3 rejected");
        issue(2'b00, 7'h7F, 8'h00, "R6 page 3 intact");
        issue(2'b01, 7'h21, 8'h77, "R4 page 1 still open");
        issue(2'b00, 7'h21, 8'h00, "R4 page 1 read");
        issue(2'b11, 7'h00, 8'h00, "R7 status three locks");
        idle(3);

        // reset restores the image and clears user locks
        apply_reset();
        issue(2'b11, 7'h00, 8'h00, "R2 status after second reset");
        issue(2'b00, 7'h20, 8'h00, "R2 page 1 blank again");
        issue(2'b00, 7'h7F, 8'h00, "R2 page 3 blank again");
        issue(2'b00, 7'h0E, 8'h00, "R1 check byte after reset");
        issue(2'b01, 7'h40, 8'h3C, "R4 page 2 open after reset");
        issue(2'b00, 7'h40, 8'h00, "R4 page 2 read");
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R3 missing responses: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule